// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block is the arbitration core of an eight-line interrupt controller. Each request line is captured into a pending register. A per-line trigger-mode bit makes the line edge-sensitive or level-sensitive. A mask vector removes lines from arbitration without stopping them from being captured. A programmable rotation base sets which line currently has the highest priority.

The winning pending line is compared with the highest-priority line that the surrounding controller reports as in service. The interrupt output is raised only when the winner strictly outranks that line. The surrounding logic decodes commands and runs acknowledge cycles. It supplies the in-service vector and per-line clear pulses for edge-captured requests.

Two build-time options shape each instance: which trigger-mode bits may be programmed, and whether the instance is the master of a cascade. On a master, a nested-mode input can hide the cascade line's in-service bit, so that further requests from the slave still get through.

Top module: `prio_resolver`

## Requirements
- R1: A line whose effective trigger bit is 1 (level mode) has its pending bit equal to the input level sampled at the previous clock edge, rising and falling with it.
- R2: A line in edge mode (effective trigger bit 0) sets its pending bit on a 0-to-1 input transition between two edges. A falling input never clears it.
- R3: A 1 in `req_clr` clears an edge-mode pending bit at the next edge, unless a rising transition on that line occurs in the same cycle, in which case the bit stays set. `req_clr` has no effect on level-mode lines.
- R4: The effective trigger mode is `trig_level & TRIG_WMASK`. Lines whose bit in `TRIG_WMASK` is 0 always behave as edge mode: lines 0 to 2 on a master built with 8'hF8, and lines 0 and 5 on a slave built with 8'hDE.
- R5: A masked line (mask bit 1) still captures requests into `pending`, but it is never reported as the winner.
- R6: Line (rot_base + k) mod 8 has priority k, where 0 is the highest. `out_idx` reports the line of the highest-priority unmasked pending request.
- R7: With no unmasked pending bit, `out_valid`, `irq_out` and `out_idx` are all 0.
- R8: `irq_out` is 1 only when the winner's priority is strictly higher than the highest priority present in `in_service`. An equal or lower priority gives `out_valid` = 1 with `irq_out` = 0. An empty `in_service` never blocks.
- R9: When `nested_en` is 1 on an instance built with IS_MASTER = 1, the in-service bit of line CASCADE (2) is left out of the in-service priority. A slave instance never leaves it out.
- R10: `pending` updates one edge after its inputs. `out_idx`, `out_valid` and `irq_out` are registered from the `pending`, `mask`, `in_service`, `rot_base` and `nested_en` values present at that edge.
- R11: While `rst_n` is low, all outputs and the stored previous-level vector are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | N | Request lines |
| trig_level | input | N | Trigger mode per line, 1 = level |
| mask | input | N | Arbitration mask per line, 1 = excluded |
| rot_base | input | log2 N | Line holding priority 0 |
| in_service | input | N | Lines currently being serviced |
| req_clr | input | N | Clear pulses for edge-captured requests |
| nested_en | input | 1 | Nested mode: ignore the cascade line in service (master only) |
| pending | output | N | Captured request register |
| out_idx | output | log2 N | Winning line index |
| out_valid | output | 1 | An unmasked request is pending |
| irq_out | output | 1 | Winner outranks everything in service |

## Verification
The bench builds two instances side by side from the same stimulus. One is a master with trigger write mask 8'hF8 and IS_MASTER = 1. The other is a slave with mask 8'hDE and IS_MASTER = 0. Because the two instances fix different lines to edge mode, one input sequence makes line 2 and line 5 behave in opposite ways on the two instances. The same pairing lets a single in-service pattern on line 2 raise the interrupt on the master in nested mode while the slave keeps it blocked.

// File: rtl/prio_resolver.sv
module prio_resolver #(
  parameter int             N          = 8,
  parameter logic [N-1:0]   TRIG_WMASK = 8'hF8,
  parameter bit             IS_MASTER  = 1'b1,
  parameter int             CASCADE    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N-1:0]             req_in,
  input  logic [N-1:0]             trig_level,
  input  logic [N-1:0]             mask,
  input  logic [$clog2(N)-1:0]     rot_base,
  input  logic [N-1:0]             in_service,
  input  logic [N-1:0]             req_clr,
  input  logic                     nested_en,
  output logic [N-1:0]             pending,
  output logic [$clog2(N)-1:0]     out_idx,
  output logic                     out_valid,
  output logic                     irq_out
);
  localparam int            IW      = $clog2(N);
  localparam logic [IW:0]   NONE    = (IW+1)'(N);
  localparam logic [N-1:0]  CAS_BIT = IS_MASTER ? (N'(1) << CASCADE) : '0;

  function automatic logic [IW:0] rank(input logic [N-1:0] v, input logic [IW-1:0] b);
    logic [IW:0] r;
    r = NONE;
    for (int k = N - 1; k >= 0; k--)
      if (v[(int'(b) + k) % N]) r = (IW+1)'(k);
    return r;
  endfunction

  logic [N-1:0]  prev_q, lvl, rise, pend_d, cand, svc;
  logic [IW:0]   win, cur;
  logic [IW-1:0] win_idx;

  assign lvl     = trig_level & TRIG_WMASK;
  assign rise    = req_in & ~prev_q;
  assign pend_d  = (lvl & req_in) | (~lvl & ((pending & ~req_clr) | rise));
  assign cand    = pending & ~mask;
  assign svc     = nested_en ? (in_service & ~CAS_BIT) : in_service;
  assign win     = rank(cand, rot_base);
  assign cur     = rank(svc, rot_base);
  assign win_idx = IW'((int'(win) + int'(rot_base)) % N);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q    <= '0;
      pending   <= '0;
      out_idx   <= '0;
      out_valid <= 1'b0;
      irq_out   <= 1'b0;
    end else begin
      prev_q    <= req_in;
      pending   <= pend_d;
      out_valid <= (win != NONE);
      irq_out   <= (win < cur);
      out_idx   <= (win != NONE) ? win_idx : '0;
    end
  end
endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk #(
  parameter int             N          = 8,
  parameter logic [N-1:0]   TRIG_WMASK = 8'hF8,
  parameter bit             IS_MASTER  = 1'b1,
  parameter int             CASCADE    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N-1:0]         req_in,
  input logic [N-1:0]         trig_level,
  input logic [N-1:0]         mask,
  input logic [N-1:0]         req_clr,
  input logic [N-1:0]         pending,
  input logic [$clog2(N)-1:0] out_idx,
  input logic                 out_valid,
  input logic                 irq_out
);
  a_r1_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_level[N-1] && TRIG_WMASK[N-1]) |=> pending[N-1] == $past(req_in[N-1]));

  a_r2_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(trig_level[N-1] && TRIG_WMASK[N-1]) && pending[N-1] && !req_clr[N-1]) |=> pending[N-1]);

  a_r5_winner_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (($past(pending & ~mask) & (N'(1) << out_idx)) != '0));

  a_r7_none_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ((pending & ~mask) == '0) |=> !out_valid);

  a_r8_irq_needs_winner: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> out_valid);
endmodule

bind prio_resolver prio_resolver_chk #(
  .N(N), .TRIG_WMASK(TRIG_WMASK), .IS_MASTER(IS_MASTER), .CASCADE(CASCADE)
) u_chk (.*);

// File: tb/test_prio_resolver.sv
module test_prio_resolver;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_in = '0, trig_level = '0, mask = '0, in_service = '0, req_clr = '0;
  logic [2:0] rot_base = '0;
  logic       nested_en = 1'b0;

  logic [7:0] pend_m, pend_s;
  logic [2:0] idx_m, idx_s;
  logic       v_m, v_s, irq_m, irq_s;

  int total = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  prio_resolver #(.N(8), .TRIG_WMASK(8'hF8), .IS_MASTER(1'b1), .CASCADE(2)) i_prio_resolver (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .trig_level(trig_level), .mask(mask),
    .rot_base(rot_base), .in_service(in_service), .req_clr(req_clr), .nested_en(nested_en),
    .pending(pend_m), .out_idx(idx_m), .out_valid(v_m), .irq_out(irq_m));

  prio_resolver #(.N(8), .TRIG_WMASK(8'hDE), .IS_MASTER(1'b0), .CASCADE(2)) i_prio_resolver_slave (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .trig_level(trig_level), .mask(mask),
    .rot_base(rot_base), .in_service(in_service), .req_clr(req_clr), .nested_en(nested_en),
    .pending(pend_s), .out_idx(idx_s), .out_valid(v_s), .irq_out(irq_s));

  typedef struct {
    string      tag;
    bit         slave;
    bit         full;
    logic [7:0] pend;
    logic [2:0] idx;
    logic       v;
    logic       irq;
  } item_t;

  item_t q[$];

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_both(string tag, bit full, logic [7:0] pm, logic [7:0] ps,
                             logic [2:0] idx, logic v, logic im, logic is_);
    q.push_back('{tag, 1'b0, full, pm, idx, v, im});
    q.push_back('{tag, 1'b1, full, ps, idx, v, is_});
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] ap;
        logic [2:0] ai;
        logic av, aq;
        it = q.pop_front();
        ap = it.slave ? pend_s : pend_m;
        ai = it.slave ? idx_s  : idx_m;
        av = it.slave ? v_s    : v_m;
        aq = it.slave ? irq_s  : irq_m;
        total++;
        if (ap !== it.pend || (it.full && (ai !== it.idx || av !== it.v || aq !== it.irq))) begin
          fails++;
          $display("FAIL %s (%s): pend=%h idx=%0d v=%b irq=%b expected pend=%h idx=%0d v=%b irq=%b",
                   it.tag, it.slave ? "slave" : "master", ap, ai, av, aq,
                   it.pend, it.idx, it.v, it.irq);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    expect_both("R11 reset", 1, 8'h00, 8'h00, 3'd0, 0, 0, 0);
    rst_n = 1'b1;
    tick();
    expect_both("R11 after reset", 1, 8'h00, 8'h00, 3'd0, 0, 0, 0);

    req_in = 8'h10; tick();
    expect_both("R2 rise captured, R10 outputs lag", 1, 8'h10, 8'h10, 3'd0, 0, 0, 0);
    tick();
    expect_both("R10 outputs follow pending", 1, 8'h10, 8'h10, 3'd4, 1, 1, 1);
    req_in = 8'h00; tick();
    expect_both("R2 fall keeps pending", 1, 8'h10, 8'h10, 3'd4, 1, 1, 1);
    req_clr = 8'h10; tick();
    expect_both("R3 clear", 1, 8'h00, 8'h00, 3'd4, 1, 1, 1);
    req_clr = 8'h00; tick();
    expect_both("R7 nothing pending", 1, 8'h00, 8'h00, 3'd0, 0, 0, 0);
    req_in = 8'h10; req_clr = 8'h10; tick();
    expect_both("R3 rise wins over clear", 1, 8'h10, 8'h10, 3'd0, 0, 0, 0);
    req_in = 8'h00; tick();
    expect_both("R3 clear after rise", 1, 8'h00, 8'h00, 3'd4, 1, 1, 1);

    req_clr = 8'h00; trig_level = 8'hFF; req_in = 8'h81; tick();
    expect_both("R1 level set", 0, 8'h81, 8'h81, 3'd0, 0, 0, 0);
    req_in = 8'h00; tick();
    expect_both("R1 level follows fall", 0, 8'h01, 8'h01, 3'd0, 0, 0, 0);
    req_in = 8'h24; tick();
    expect_both("R4 lines 2 and 5 rise", 0, 8'h25, 8'h25, 3'd0, 0, 0, 0);
    req_in = 8'h00; tick();
    expect_both("R4 fixed edge lines differ", 0, 8'h05, 8'h21, 3'd0, 0, 0, 0);
    req_in = 8'h80; req_clr = 8'h80; tick();
    expect_both("R3 clear ignored on level line", 0, 8'h85, 8'hA1, 3'd0, 0, 0, 0);
    trig_level = 8'h00; req_in = 8'h00; req_clr = 8'hFF; tick();
    expect_both("R3 clear all edge", 0, 8'h00, 8'h00, 3'd0, 0, 0, 0);
    req_clr = 8'h00; tick();
    expect_both("R7 idle", 1, 8'h00, 8'h00, 3'd0, 0, 0, 0);

    req_in = 8'h11; tick();
    expect_both("R2 two rises", 0, 8'h11, 8'h11, 3'd0, 0, 0, 0);
    tick();
    expect_both("R6 base 0", 1, 8'h11, 8'h11, 3'd0, 1, 1, 1);
    rot_base = 3'd5; tick();
    expect_both("R6 base 5", 1, 8'h11, 8'h11, 3'd0, 1, 1, 1);
    rot_base = 3'd2; tick();
    expect_both("R6 base 2", 1, 8'h11, 8'h11, 3'd4, 1, 1, 1);
    rot_base = 3'd1; tick();
    expect_both("R6 base 1", 1, 8'h11, 8'h11, 3'd4, 1, 1, 1);
    rot_base = 3'd0; mask = 8'h01; tick();
    expect_both("R5 masked line skipped", 1, 8'h11, 8'h11, 3'd4, 1, 1, 1);
    mask = 8'h11; tick();
    expect_both("R7 all masked", 1, 8'h11, 8'h11, 3'd0, 0, 0, 0);
    mask = 8'hFF; req_in = 8'h51; tick();
    expect_both("R5 capture while masked", 1, 8'h51, 8'h51, 3'd0, 0, 0, 0);
    mask = 8'h01; tick();
    expect_both("R5 unmask", 1, 8'h51, 8'h51, 3'd4, 1, 1, 1);

    in_service = 8'h10; tick();
    expect_both("R8 equal priority blocks", 1, 8'h51, 8'h51, 3'd4, 1, 0, 0);
    in_service = 8'h20; tick();
    expect_both("R8 lower in service", 1, 8'h51, 8'h51, 3'd4, 1, 1, 1);
    in_service = 8'h08; tick();
    expect_both("R8 higher in service", 1, 8'h51, 8'h51, 3'd4, 1, 0, 0);
    in_service = 8'h04; tick();
    expect_both("R9 nested off", 1, 8'h51, 8'h51, 3'd4, 1, 0, 0);
    nested_en = 1'b1; tick();
    expect_both("R9 nested hides cascade on master", 1, 8'h51, 8'h51, 3'd4, 1, 1, 0);
    in_service = 8'h0C; tick();
    expect_both("R9 other line still blocks", 1, 8'h51, 8'h51, 3'd4, 1, 0, 0);
    nested_en = 1'b0; rot_base = 3'd4; in_service = 8'h01; tick();
    expect_both("R8 rotated in-service", 1, 8'h51, 8'h51, 3'd4, 1, 1, 1);
    in_service = 8'h10; tick();
    expect_both("R8 rotated equal", 1, 8'h51, 8'h51, 3'd4, 1, 0, 0);

    tick(); tick();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule